// File: doc/BRIEF.md
# Idle Clock Divider with Interrupt Wake

This block controls the core clock enable of a processor for two idle modes. A halting idle stops the core outright until an interrupt that is not masked arrives. A slow idle keeps the core alive but lets it advance only once every n base-clock cycles. n is chosen by a two-bit code, and the serial, output and timer clock enables are divided by the same n. While the block is in either idle mode, cycle-steal requests from DMA and autobuffer engines keep being granted.

An idle request is taken only while the core runs. It carries a mode bit and a divisor code, and both are captured at that moment. In slow idle an unmasked interrupt is remembered, and the return to full rate waits for the end of the current divided period. The wake latency is therefore at most n base cycles. When the core resumes, it continues with the instruction that follows the idle request.

Top module: `idle_clk_ctl`

## Requirements
- R1: After reset the core enable and every derived enable are 1, the idle flag is 0 and the DMA grant is 0.
- R2: An idle request taken while running with the slow bit at 0 sets the idle flag and clears the core enable from the next cycle on, until a wake.
- R3: In halting idle, an unmasked interrupt present in a cycle brings the core enable back to 1 and the idle flag to 0 in the following cycle.
- R4: A mask bit of 1 blocks its interrupt line. Such a request neither ends halting idle nor arms a wake in slow idle.
- R5: An idle request with the slow bit at 1 makes the core enable a one-cycle pulse every n cycles. n is 16 for code 00, 32 for 01, 64 for 10 and 128 for 11. The first pulse comes in the n-th cycle after the request edge.
- R6: The serial, output and timer enables (bits 0, 1 and 2 of the derived enable bus) equal the core enable in every cycle.
- R7: In slow idle, an unmasked interrupt, even a single-cycle one, ends idle after the first enable pulse at or after its arrival. Full rate returns in the cycle after that pulse, no more than n cycles after the interrupt.
- R8: A DMA cycle-steal request is granted in the following cycle in every state, idle or not.
- R9: An idle request that arrives while the block is already idle is ignored.
- R10: The divisor code is captured with the request. A change on the code input during idle does not alter the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req_i | input | 1 | Idle request pulse |
| idle_slow_i | input | 1 | 1 selects slow idle, 0 selects halting idle |
| idle_code_i | input | 2 | Divisor code for slow idle |
| irq_i | input | 4 | Interrupt request lines |
| irq_mask_i | input | 4 | Mask per line, 1 blocks the line |
| dma_req_i | input | 1 | Cycle-steal request |
| core_ce_o | output | 1 | Core clock enable |
| aux_ce_o | output | 3 | Serial, output and timer clock enables |
| idle_o | output | 1 | High while in either idle mode |
| dma_gnt_o | output | 1 | Cycle-steal grant |

## Verification
Two events can fall in the same cycle: an interrupt arriving and the divided enable pulse firing. When they coincide, the block must wake at once. One cycle later, it must wait a full period. The bench sweeps the interrupt arrival over every cycle offset from 1 to n+1 for each of the four codes. It computes the wake cycle as the next multiple of n at or after the arrival and checks every enable and the idle flag in every cycle of the window. The same sweep keeps a masked line high throughout, sends an idle request with another code in mid-idle, and toggles the DMA request, so masking, the ignored request and the grant are all judged on the same vectors.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_SLOW = 2'd2
  } idle_st_e;
endpackage

// File: rtl/idle_divcnt.sv
module idle_divcnt #(
  parameter int CODE_W    = 2,
  parameter int CNT_W     = 7,
  parameter int BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int TOP_SH = CNT_W - BASE_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  // limit = n-1 = 2^(BASE_LOG2+code) - 1
  always_comb begin
    limit = {CNT_W{1'b1}} >> (TOP_SH - int'(code_i));
  end

  assign tick_o = run_i && (cnt_q == limit);

  always_comb begin
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= limit));
  assert_tick_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/idle_wake.sv
module idle_wake #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] mask_i,
  output logic            wake_now_o,
  output logic            pend_o
);
  logic pend_q, pend_d;

  assign wake_now_o = |(irq_i & ~mask_i);
  assign pend_o     = pend_q;

  always_comb begin
    if (arm_i) pend_d = pend_q | wake_now_o;
    else       pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && ((irq_i & ~mask_i) == '0) && !pend_q) |=> !pend_q);
  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && pend_q) |=> (pend_q || !arm_i));
endmodule

// File: rtl/idle_clk_ctl.sv
module idle_clk_ctl
  import idle_ctl_pkg::*;
#(
  parameter int NIRQ      = 4,
  parameter int CODE_W    = 2,
  parameter int CNT_W     = 7,
  parameter int BASE_LOG2 = 4,
  parameter int NCE       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req_i,
  input  logic              idle_slow_i,
  input  logic [CODE_W-1:0] idle_code_i,
  input  logic [NIRQ-1:0]   irq_i,
  input  logic [NIRQ-1:0]   irq_mask_i,
  input  logic              dma_req_i,
  output logic              core_ce_o,
  output logic [NCE-1:0]    aux_ce_o,
  output logic              idle_o,
  output logic              dma_gnt_o
);
  idle_st_e          st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              gnt_q;
  logic              tick, wake_now, pend;

  idle_divcnt #(.CODE_W(CODE_W), .CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == ST_SLOW),
    .code_i (code_q),
    .tick_o (tick)
  );

  idle_wake #(.NIRQ(NIRQ)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (st_q == ST_SLOW),
    .irq_i      (irq_i),
    .mask_i     (irq_mask_i),
    .wake_now_o (wake_now),
    .pend_o     (pend)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    case (st_q)
      ST_RUN: begin
        if (idle_req_i) begin
          st_d   = idle_slow_i ? ST_SLOW : ST_HALT;
          code_d = idle_code_i;
        end
      end
      ST_HALT: if (wake_now) st_d = ST_RUN;
      ST_SLOW: if (tick && (pend || wake_now)) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      code_q <= '0;
      gnt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      gnt_q  <= dma_req_i;
    end
  end

  always_comb begin
    case (st_q)
      ST_RUN:  core_ce_o = 1'b1;
      ST_SLOW: core_ce_o = tick;
      default: core_ce_o = 1'b0;
    endcase
  end

  for (genvar gi = 0; gi < NCE; gi++) begin : g_aux
    assign aux_ce_o[gi] = core_ce_o;
  end

  assign idle_o    = (st_q != ST_RUN);
  assign dma_gnt_o = gnt_q;

  assert_halt_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |-> !core_ce_o);
  assert_std_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && wake_now) |=> (core_ce_o && !idle_o));
  assert_slow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLOW && !tick) |=> idle_o);
  assert_dma_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_i |=> dma_gnt_o);
  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN) |=> $stable(code_q));
  assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !wake_now && idle_req_i) |=> (st_q == ST_HALT));
endmodule

// File: tb/sim_idle_clk_ctl.sv
module sim_idle_clk_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       idle_req_i, idle_slow_i, dma_req_i;
  logic [1:0] idle_code_i;
  logic [3:0] irq_i, irq_mask_i;
  logic       core_ce_o, idle_o, dma_gnt_o;
  logic [2:0] aux_ce_o;

  int  nvec = 0;
  int  nbad = 0;
  bit  done = 1'b0;
  logic dma_last = 1'b0;

  always #4 clk = ~clk;

  idle_clk_ctl u0 (
    .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req_i), .idle_slow_i(idle_slow_i),
    .idle_code_i(idle_code_i), .irq_i(irq_i), .irq_mask_i(irq_mask_i),
    .dma_req_i(dma_req_i), .core_ce_o(core_ce_o), .aux_ce_o(aux_ce_o),
    .idle_o(idle_o), .dma_gnt_o(dma_gnt_o)
  );

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check_outs(string tag, logic e_core, logic e_idle);
    chk({tag, " core enable"}, {2'b0, core_ce_o}, {2'b0, e_core});
    chk({tag, " idle flag"},   {2'b0, idle_o},    {2'b0, e_idle});
    chk("R6 derived enables", aux_ce_o, {3{e_core}});
    chk("R8 dma grant", {2'b0, dma_gnt_o}, {2'b0, dma_last});
  endtask

  // one vector: enter idle in cycle 0, unmasked irq pulse in cycle off
  task automatic run_vec(bit slow, int code, int off);
    int n, w;
    n = slow ? (16 << code) : 1;
    w = ((off + n - 1) / n) * n;
    idle_req_i  = 1'b1;
    idle_slow_i = slow;
    idle_code_i = 2'(code);
    irq_i[1]    = 1'b0;
    dma_req_i   = 1'b0;
    dma_last    = dma_req_i;
    for (int c = 1; c <= w + 2; c++) begin
      step();
      if (c <= w) begin
        if (slow) check_outs("R5 R10", (c % n) == 0, 1'b1);
        else      check_outs("R2 R4 R9", 1'b0, 1'b1);
      end else begin
        if (slow) check_outs("R7 R4", 1'b1, 1'b0);
        else      check_outs("R3", 1'b1, 1'b0);
      end
      idle_req_i = 1'b0;
      if (c == 2 && c <= w) begin
        idle_req_i  = 1'b1;          // ignored while idle
        idle_slow_i = ~slow;
        idle_code_i = ~2'(code);
      end
      irq_i[1]  = (c == off);
      dma_req_i = ((c * 7 + off) % 3) == 0;
      dma_last  = dma_req_i;
    end
    idle_req_i = 1'b0;
  endtask

  initial begin
    rst_n       = 1'b0;
    idle_req_i  = 1'b0;
    idle_slow_i = 1'b0;
    idle_code_i = 2'b00;
    irq_mask_i  = 4'b0001;           // line 0 masked and held high
    irq_i       = 4'b0001;
    dma_req_i   = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 core enable in reset", {2'b0, core_ce_o}, 3'b001);
    chk("R1 idle flag in reset",   {2'b0, idle_o},    3'b000);
    rst_n = 1'b1;
    step();
    chk("R1 derived enables", aux_ce_o, 3'b111);
    chk("R1 dma grant", {2'b0, dma_gnt_o}, 3'b000);
    for (int off = 1; off <= 10; off++) run_vec(1'b0, 0, off);
    for (int code = 0; code < 4; code++)
      for (int off = 1; off <= (16 << code) + 1; off++) run_vec(1'b1, code, off);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nbad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule